// File: doc/BRIEF.md
# Radio Interrupt Aggregator with Mask Mode

This block collects event pulses from a radio transceiver core and turns them into one interrupt request pin plus a small set of host-visible registers. Each of eight event lines is held in a sticky status bit. An enable register chooses which held bits can raise the pin. A control register sets the pin's active level and the mask-mode behaviour. Reading the status register returns the held bits and empties it in the same access. An event that arrives during that read is kept, not lost.

With mask mode off, an event whose enable bit is 0 is dropped completely. With mask mode on, the same event is still recorded in status but never drives the pin, so software can poll for it without getting any timing information. Status bit 4 has two meanings. Outside receive states it carries the wake-up-complete pulse, which arrives on event line 4. In receive states it carries the measurement-done pulse, which has a separate input. The `trx_in_rx` input selects which of the two is used.

The register port is plain and always accepts an access, so the host sees no back-pressure. A write takes effect at the clock edge where `reg_we` is sampled. Read data appears on `reg_rdata` one cycle after `reg_re` is sampled and holds until the next read.

Top module: `irq_hub`

## Requirements
- R1: After reset the enable register (address 0x0E), the control register (address 0x04) and the status register (address 0x0F) all read 0, and `irq_pin` is low.
- R2: A write to address 0x0E stores all eight bits, and a later read of 0x0E returns them. In the enable register, bit 0 enables event 0, bit 1 enables event 1, and so on up to bit 7.
- R3: A pulse on an enabled event line sets the matching status bit at that clock edge. The pin is then active from the following cycle, because the pin is active while (status AND enable) is nonzero.
- R4: With control bit 1 (mask mode) at 0, a pulse on an event line whose enable bit is 0 is neither recorded in status nor seen on the pin.
- R5: With control bit 1 at 1, a pulse on a disabled event line is recorded in status but leaves the pin inactive.
- R6: A read of 0x0F returns the held status bits and clears them. The pin returns to inactive in the cycle after the read.
- R7: An event pulse sampled at the same edge as a status read is absent from that read's data but present in status afterwards.
- R8: Control bit 0 sets the pin polarity. When it is 0 the pin is high while a request is pending. When it is 1 the pin is low while a request is pending and high otherwise.
- R9: Status bit 4 is taken from event line 4 (wake-up complete) when `trx_in_rx` is 0, and from `meas_done` when `trx_in_rx` is 1. The source that is not selected has no effect.
- R10: Writes to 0x0F have no effect on status, and a read from any address other than 0x04, 0x0E or 0x0F returns 0.
- R11: `reg_rdata` changes only on a cycle after `reg_re` was sampled high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 8 | Single-cycle event pulses; line 4 is wake-up complete |
| meas_done | input | 1 | Single-cycle measurement-finished pulse |
| trx_in_rx | input | 1 | High while the transceiver is in a receive state |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| irq_pin | output | 1 | Interrupt request, level set by the polarity bit |

## Verification
Clear-on-read and event capture can fall in the same clock edge. The bench provokes this by raising `reg_re` at address 0x0F in the same cycle as an event pulse. The scoreboard then checks that this read returns only the earlier bits, and that a second read returns the new event. A second collision comes from mask mode: a disabled event is recorded without raising the pin. The bench judges this by sampling the pin and then reading status.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 8'h04;
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 8'h0E;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 8'h0F;
  localparam int unsigned CTRL_POL_BIT  = 0;
  localparam int unsigned CTRL_MODE_BIT = 1;
  localparam int unsigned DUAL_BIT      = 4;

  typedef struct packed {
    logic mask_mode;
    logic pol_low;
  } irq_ctrl_t;
endpackage

// File: rtl/irq_src_sel.sv
module irq_src_sel
  import irq_hub_pkg::*;
#(
  parameter int unsigned W    = DATA_W,
  parameter int unsigned DUAL = DUAL_BIT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_raw,
  input  logic         meas_done,
  input  logic         in_rx,
  output logic [W-1:0] evt_eff
);
  for (genvar i = 0; i < W; i++) begin : g_src
    if (i == DUAL) begin : g_dual
      assign evt_eff[i] = in_rx ? meas_done : evt_raw[i];
    end else begin : g_plain
      assign evt_eff[i] = evt_raw[i];
    end
  end

  AST_RX_IGNORES_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rx && !meas_done) |-> !evt_eff[DUAL]); // R9
  AST_IDLE_IGNORES_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_rx && !evt_raw[DUAL]) |-> !evt_eff[DUAL]); // R9
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_hub_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic          we,
  output logic [W-1:0]  enable_q,
  output irq_ctrl_t     ctrl_q
);
  logic hit_enable, hit_ctrl;
  assign hit_enable = we && (addr == ADDR_ENABLE);
  assign hit_ctrl   = we && (addr == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= '0;
      ctrl_q   <= '0;
    end else begin
      if (hit_enable) enable_q <= wdata;
      if (hit_ctrl) begin
        ctrl_q.pol_low   <= wdata[CTRL_POL_BIT];
        ctrl_q.mask_mode <= wdata[CTRL_MODE_BIT];
      end
    end
  end

  AST_ENABLE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_enable |=> $stable(enable_q)); // R2
endmodule

// File: rtl/irq_status_latch.sv
module irq_status_latch
  import irq_hub_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] enable,
  input  logic         mask_mode,
  input  logic         clr,
  output logic [W-1:0] status_q
);
  logic [W-1:0] capture;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign capture[i] = evt[i] & (enable[i] | mask_mode);
    always_ff @(posedge clk) begin
      if (!rst_n) status_q[i] <= 1'b0;
      else        status_q[i] <= (status_q[i] & ~clr) | capture[i];
    end
  end

  AST_KEEP_NEW_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (capture != '0)) |=> (status_q != '0)); // R7
  AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (capture == '0)) |=> $stable(status_q)); // R10
  AST_DROP_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_mode && clr) |=> ((status_q & ~$past(enable)) == '0)); // R4
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import irq_hub_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          re,
  input  logic [W-1:0]  enable,
  input  irq_ctrl_t     ctrl,
  input  logic [W-1:0]  status,
  output logic          clr_status,
  output logic [W-1:0]  rdata_q
);
  logic [W-1:0] ctrl_word;
  logic [W-1:0] sel;

  always_comb begin
    ctrl_word                = '0;
    ctrl_word[CTRL_POL_BIT]  = ctrl.pol_low;
    ctrl_word[CTRL_MODE_BIT] = ctrl.mask_mode;
  end

  always_comb begin
    unique case (addr)
      ADDR_ENABLE: sel = enable;
      ADDR_CTRL:   sel = ctrl_word;
      ADDR_STATUS: sel = status;
      default:     sel = '0;
    endcase
  end

  assign clr_status = re && (addr == ADDR_STATUS);

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata_q <= '0;
    else if (re) rdata_q <= sel;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rdata_q)); // R11
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive
  import irq_hub_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status,
  input  logic [W-1:0] enable,
  input  logic         pol_low,
  output logic         pin
);
  logic pending;
  assign pending = |(status & enable);
  assign pin     = pending ^ pol_low;

  AST_NO_ENABLE_NO_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> (pin == pol_low)); // R5
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] evt_pulse,
  input  logic              meas_done,
  input  logic              trx_in_rx,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  input  logic              reg_re,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_pin
);
  logic [DATA_W-1:0] evt_eff;
  logic [DATA_W-1:0] enable_q;
  logic [DATA_W-1:0] status_q;
  irq_ctrl_t         ctrl_q;
  logic              clr_status;

  irq_src_sel #(.W(DATA_W), .DUAL(DUAL_BIT)) u_src (
    .clk(clk), .rst_n(rst_n), .evt_raw(evt_pulse), .meas_done(meas_done),
    .in_rx(trx_in_rx), .evt_eff(evt_eff)
  );

  irq_cfg_regs #(.W(DATA_W), .AW(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
    .we(reg_we), .enable_q(enable_q), .ctrl_q(ctrl_q)
  );

  irq_status_latch #(.W(DATA_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .evt(evt_eff), .enable(enable_q),
    .mask_mode(ctrl_q.mask_mode), .clr(clr_status), .status_q(status_q)
  );

  irq_read_port #(.W(DATA_W), .AW(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .re(reg_re),
    .enable(enable_q), .ctrl(ctrl_q), .status(status_q),
    .clr_status(clr_status), .rdata_q(reg_rdata)
  );

  irq_pin_drive #(.W(DATA_W)) u_pin (
    .clk(clk), .rst_n(rst_n), .status(status_q), .enable(enable_q),
    .pol_low(ctrl_q.pol_low), .pin(irq_pin)
  );

  AST_PIN_IDLE_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_status && (evt_pulse == '0) && !meas_done) |=> (irq_pin == ctrl_q.pol_low)); // R6
endmodule

// File: tb/tb_irq_hub.sv
module tb_irq_hub;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_pulse = '0;
  logic       meas_done = 1'b0;
  logic       trx_in_rx = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_we = 1'b0;
  logic       reg_re = 1'b0;
  logic [7:0] reg_rdata;
  logic       irq_pin;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic re_d = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  irq_hub dut (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .meas_done(meas_done),
    .trx_in_rx(trx_in_rx), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata), .irq_pin(irq_pin)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares read data one cycle after each sampled read strobe
  always @(posedge clk) re_d <= reg_re && rst_n;
  always @(negedge clk) begin
    if (re_d) begin
      if (exp_q.size() == 0) chk(1'b0, "scoreboard underflow", reg_rdata, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(reg_rdata == e, t, reg_rdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t,
                    input logic [7:0] ev = 8'h00);
    @(negedge clk); reg_addr = a; reg_re = 1'b1; evt_pulse = ev;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); reg_re = 1'b0; evt_pulse = '0;
  endtask

  task automatic pulse(input logic [7:0] ev, input logic md, input logic rx);
    @(negedge clk); evt_pulse = ev; meas_done = md; trx_in_rx = rx;
    @(negedge clk); evt_pulse = '0; meas_done = 1'b0;
  endtask

  task automatic pin_is(input logic e, input string t);
    chk(irq_pin === e, t, irq_pin, e);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung, expected finish");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    pin_is(1'b0, "R1 pin after reset");
    rd(8'h0E, 8'h00, "R1 enable after reset");
    rd(8'h04, 8'h00, "R1 ctrl after reset");
    rd(8'h0F, 8'h00, "R1 status after reset");

    wr(8'h0E, 8'hA5);
    rd(8'h0E, 8'hA5, "R2 enable readback");
    wr(8'h0E, 8'h01);
    rd(8'h0E, 8'h01, "R2 enable readback 2");

    pulse(8'h01, 1'b0, 1'b0);
    pin_is(1'b1, "R3 pin after enabled event");
    rd(8'h0F, 8'h01, "R6 status read returns event");
    pin_is(1'b0, "R6 pin idle after clear");
    rd(8'h0F, 8'h00, "R6 status empty after clear");

    pulse(8'h80, 1'b0, 1'b0);
    pin_is(1'b0, "R4 pin for disabled event");
    rd(8'h0F, 8'h00, "R4 disabled event dropped");

    wr(8'h04, 8'h02);
    rd(8'h04, 8'h02, "R5 ctrl readback");
    pulse(8'h80, 1'b0, 1'b0);
    pin_is(1'b0, "R5 pin stays idle in mask mode");
    rd(8'h0F, 8'h80, "R5 disabled event recorded");

    pulse(8'h01, 1'b0, 1'b0);
    pin_is(1'b1, "R7 pin before collision");
    rd(8'h0F, 8'h01, "R7 collision read has old bits", 8'h04);
    rd(8'h0F, 8'h04, "R7 collided event kept");

    wr(8'h04, 8'h01);
    pin_is(1'b1, "R8 active-low idle level");
    pulse(8'h01, 1'b0, 1'b0);
    pin_is(1'b0, "R8 active-low pending");
    rd(8'h0F, 8'h01, "R8 status read");
    pin_is(1'b1, "R8 active-low idle after clear");

    wr(8'h04, 8'h00);
    wr(8'h0E, 8'h10);
    pulse(8'h10, 1'b0, 1'b0);
    pin_is(1'b1, "R9 wake-up raises pin outside rx");
    rd(8'h0F, 8'h10, "R9 wake-up recorded outside rx");
    pulse(8'h00, 1'b1, 1'b0);
    rd(8'h0F, 8'h00, "R9 measurement ignored outside rx");
    pulse(8'h00, 1'b1, 1'b1);
    pin_is(1'b1, "R9 measurement raises pin in rx");
    rd(8'h0F, 8'h10, "R9 measurement recorded in rx");
    pulse(8'h10, 1'b0, 1'b1);
    pin_is(1'b0, "R9 wake-up ignored in rx");
    rd(8'h0F, 8'h00, "R9 wake-up not recorded in rx");

    wr(8'h0F, 8'hFF);
    pin_is(1'b0, "R10 status write no pin");
    rd(8'h0F, 8'h00, "R10 status write ignored");
    wr(8'h33, 8'h5A);
    rd(8'h33, 8'h00, "R10 unmapped read zero");
    rd(8'h0E, 8'h10, "R10 unmapped write harmless");

    repeat (3) @(negedge clk);
    chk(reg_rdata == 8'h10, "R11 read data held", reg_rdata, 8'h10);

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule